// File: doc/BRIEF.md
# PCI Initiator Command Selector

This block sits at the head of a host-side PCI initiator. For each local request it picks the PCI bus command and decides whether the address needs a dual address cycle. For configuration accesses it builds the address phase from a configuration address register and decodes the one-hot device-select lines. It also conditions read completions, so that a master abort either reports a bus error or returns a word of all ones. The choice depends on a control bit.

A request is presented for one cycle with `req_valid`. One cycle later `out_valid` pulses with the registered command, address-phase code, DAC flag, configuration type, device-select lines, bus address and write data, or with `req_err` raised if the request cannot be issued. Read completions from the data-phase engine enter on the `rsp_*` pins and leave one cycle later on the `rd_*` pins. The bus signalling, arbitration and data phases are handled elsewhere.

Top module: `pci_cmd_select`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid`, `req_err`, `rd_valid` and `rd_berr` are 0 after that edge.
- R2: A request accepted at an edge gives `out_valid`=1 after the next edge, with `cmd_code` chosen by `req_kind` (0 mem read gives 0x6, 2 config read gives 0xA, 3 config write gives 0xB, 4 interrupt-ack read gives 0x0, 5 special-cycle write gives 0x1). `req_kind` 6 or 7 gives `req_err`=1.
- R3: A memory write (`req_kind`=1) gives 0xF only when `mwi_en`=1, `cls`≠0 and `req_words`>`cls` all hold. In every other case it gives 0x7.
- R4: For memory commands, `dac`=1 and `adr_code`=0xD when `req_addr` > 0x00_FFFF_FFFF. Otherwise `dac`=0 and `adr_code`=`cmd_code`. Non-memory commands always have `dac`=0.
- R5: A configuration access drives `bus_addr` as the zero-extended value held in the configuration address register. That register is written by `cfg_we`/`cfg_wdata` and takes effect from the next cycle.
- R6: Configuration address bits [1:0]=00 give `cfg_type`=0, and `idsel` is one-hot at the device number in bits [15:11] if that number is below NDEV, or all zero otherwise. Bits 01 give `cfg_type`=1 with `idsel` all zero. Bits 10 or 11 give `req_err`=1.
- R7: A configuration access while `host_mode`=0 is rejected with `req_err`=1.
- R8: `bus_wdata` carries `req_wdata` of the request, so a special-cycle write drives its written value as the cycle data.
- R9: A read completion without abort (including interrupt-acknowledge data) is returned unchanged one cycle later with `rd_berr`=0.
- R10: A master-aborted completion with `berr_on_rd`=1 gives `rd_berr`=1 and `rd_data`=0.
- R11: A master-aborted completion with `berr_on_rd`=0 gives `rd_berr`=0 and `rd_data` all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 3 | Request type |
| req_addr | input | 40 | Memory address |
| req_words | input | 8 | Write length in words |
| req_wdata | input | 32 | Write / special-cycle data |
| mwi_en | input | 1 | Write-and-invalidate enable |
| cls | input | 8 | Cache line size in words |
| berr_on_rd | input | 1 | Abort on read raises bus error |
| host_mode | input | 1 | Initiator is the host |
| cfg_we | input | 1 | Write strobe for configuration address register |
| cfg_wdata | input | 32 | Configuration address value |
| rsp_valid | input | 1 | Read completion strobe |
| rsp_abort | input | 1 | Completion was master-aborted |
| rsp_data | input | 32 | Completion data |
| out_valid | output | 1 | Command result strobe |
| req_err | output | 1 | Request rejected |
| cmd_code | output | 4 | Bus command of the transfer |
| adr_code | output | 4 | Command in first address phase |
| dac | output | 1 | Dual address cycle needed |
| cfg_type | output | 1 | Configuration type 0 or 1 |
| idsel | output | 21 | One-hot device select |
| bus_addr | output | 40 | Address to drive |
| bus_wdata | output | 32 | Data to drive |
| rd_valid | output | 1 | Read result strobe |
| rd_data | output | 32 | Read result |
| rd_berr | output | 1 | Read raised bus error |

## Verification
The bench tests the write-and-invalidate choice at its edges. It uses a word count equal to the line size, a zero line size and a cleared enable. A design that compares with >= or ignores one condition would issue 0xF there. It places the address exactly at 0xFFFF_FFFF and one above, which catches an off-by-one DAC threshold. It also uses a device number past the select width, config type codes 10 and non-host mode, where a wrong design would drive a stray select line or issue the cycle. Aborted reads are checked under both settings of the bus-error bit, so a swapped polarity returns the wrong data.

// File: rtl/pci_cmd_pkg.sv
// Shared request kinds and PCI command codes for the command selector.
package pci_cmd_pkg;
    typedef enum logic [2:0] {
        RQ_MEM_RD = 3'd0,
        RQ_MEM_WR = 3'd1,
        RQ_CFG_RD = 3'd2,
        RQ_CFG_WR = 3'd3,
        RQ_IACK   = 3'd4,
        RQ_SPCL   = 3'd5
    } req_kind_e;

    localparam logic [3:0] PC_IACK  = 4'h0;
    localparam logic [3:0] PC_SPCL  = 4'h1;
    localparam logic [3:0] PC_MRD   = 4'h6;
    localparam logic [3:0] PC_MWR   = 4'h7;
    localparam logic [3:0] PC_CRD   = 4'hA;
    localparam logic [3:0] PC_CWR   = 4'hB;
    localparam logic [3:0] PC_DAC   = 4'hD;
    localparam logic [3:0] PC_MWI   = 4'hF;
endpackage

// File: rtl/pci_cmd_pick.sv
// Combinational command choice. Assumes addresses wider than 32 bits
// and that line size and word count share one width.
module pci_cmd_pick
    import pci_cmd_pkg::*;
#(
    parameter int ADDR_W = 40,
    parameter int WC_W   = 8
) (
    input  logic [2:0]        kind,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WC_W-1:0]   words,
    input  logic              mwi_en,
    input  logic [WC_W-1:0]   cls,
    output logic [3:0]        cmd,
    output logic [3:0]        adr_code,
    output logic              dac,
    output logic              is_cfg,
    output logic              bad_kind
);
    logic hi_addr;
    logic mwi_ok;

    assign hi_addr = |addr[ADDR_W-1:32];
    assign mwi_ok  = mwi_en && (cls != '0) && (words > cls);

    // Map the request kind to a command and flag the DAC need.
    always_comb begin
        cmd      = PC_MRD;
        dac      = 1'b0;
        is_cfg   = 1'b0;
        bad_kind = 1'b0;
        case (req_kind_e'(kind))
            RQ_MEM_RD: begin cmd = PC_MRD; dac = hi_addr; end
            RQ_MEM_WR: begin cmd = mwi_ok ? PC_MWI : PC_MWR; dac = hi_addr; end
            RQ_CFG_RD: begin cmd = PC_CRD; is_cfg = 1'b1; end
            RQ_CFG_WR: begin cmd = PC_CWR; is_cfg = 1'b1; end
            RQ_IACK:   cmd = PC_IACK;
            RQ_SPCL:   cmd = PC_SPCL;
            default:   bad_kind = 1'b1;
        endcase
    end

    assign adr_code = dac ? PC_DAC : cmd;
endmodule

// File: rtl/pci_cfg_addr.sv
// Configuration address register with type and device-select decode.
// Assumes NDEV <= 32 so the 5-bit device field covers every line.
module pci_cfg_addr #(
    parameter int DATA_W = 32,
    parameter int NDEV   = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wd,
    output logic [DATA_W-1:0] cfg_reg,
    output logic              ctype,
    output logic              type_bad,
    output logic [NDEV-1:0]   idsel
);
    logic [4:0] dev;
    logic       type0;

    // Hold the last written configuration address.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_reg <= '0;
        else if (we) cfg_reg <= wd;
    end

    assign dev      = cfg_reg[15:11];
    assign type0    = (cfg_reg[1:0] == 2'b00);
    assign ctype    = (cfg_reg[1:0] == 2'b01);
    assign type_bad = cfg_reg[1];

    for (genvar i = 0; i < NDEV; i++) begin : g_sel
        assign idsel[i] = type0 && (dev == 5'(i));
    end
endmodule

// File: rtl/pci_rd_resp.sv
// Registered read completion path with master-abort handling.
module pci_rd_resp #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rsp_valid,
    input  logic              rsp_abort,
    input  logic [DATA_W-1:0] rsp_data,
    input  logic              berr_on_rd,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_berr
);
    // Forward data, or replace it on abort according to the control bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            rd_berr  <= 1'b0;
        end else begin
            rd_valid <= rsp_valid;
            if (rsp_valid) begin
                rd_berr <= rsp_abort && berr_on_rd;
                if (!rsp_abort)     rd_data <= rsp_data;
                else if (berr_on_rd) rd_data <= '0;
                else                rd_data <= '1;
            end
        end
    end

    // R10
    property abort_berr_p;
        @(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_abort && berr_on_rd) |=> (rd_berr && rd_data == '0);
    endproperty
    abort_berr_chk: assert property (abort_berr_p);

    // R11
    property abort_ones_p;
        @(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_abort && !berr_on_rd) |=> (!rd_berr && rd_data == '1);
    endproperty
    abort_ones_chk: assert property (abort_ones_p);
endmodule

// File: rtl/pci_cmd_select.sv
// Top: registers the chosen command, address phase and device selects
// for each request, and passes read completions through abort handling.
// Assumes one request per cycle and a single-cycle req_valid strobe.
module pci_cmd_select
    import pci_cmd_pkg::*;
#(
    parameter int ADDR_W = 40,
    parameter int DATA_W = 32,
    parameter int WC_W   = 8,
    parameter int NDEV   = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WC_W-1:0]   req_words,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              mwi_en,
    input  logic [WC_W-1:0]   cls,
    input  logic              berr_on_rd,
    input  logic              host_mode,
    input  logic              cfg_we,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              rsp_valid,
    input  logic              rsp_abort,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              out_valid,
    output logic              req_err,
    output logic [3:0]        cmd_code,
    output logic [3:0]        adr_code,
    output logic              dac,
    output logic              cfg_type,
    output logic [NDEV-1:0]   idsel,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_berr
);
    localparam int PAD_W = ADDR_W - DATA_W;

    logic [3:0]        p_cmd, p_adr;
    logic              p_dac, p_cfg, p_bad;
    logic [DATA_W-1:0] c_reg;
    logic              c_type, c_bad;
    logic [NDEV-1:0]   c_sel;
    logic              err_now;

    pci_cmd_pick #(.ADDR_W(ADDR_W), .WC_W(WC_W)) u_pick (
        .kind(req_kind), .addr(req_addr), .words(req_words),
        .mwi_en(mwi_en), .cls(cls), .cmd(p_cmd), .adr_code(p_adr),
        .dac(p_dac), .is_cfg(p_cfg), .bad_kind(p_bad)
    );

    pci_cfg_addr #(.DATA_W(DATA_W), .NDEV(NDEV)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wd(cfg_wdata),
        .cfg_reg(c_reg), .ctype(c_type), .type_bad(c_bad), .idsel(c_sel)
    );

    pci_rd_resp #(.DATA_W(DATA_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .rsp_valid(rsp_valid),
        .rsp_abort(rsp_abort), .rsp_data(rsp_data), .berr_on_rd(berr_on_rd),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_berr(rd_berr)
    );

    assign err_now = p_bad || (p_cfg && (!host_mode || c_bad));

    // Register the command result; rejected requests carry only the error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            req_err   <= 1'b0;
            cmd_code  <= '0;
            adr_code  <= '0;
            dac       <= 1'b0;
            cfg_type  <= 1'b0;
            idsel     <= '0;
            bus_addr  <= '0;
            bus_wdata <= '0;
        end else begin
            out_valid <= req_valid;
            if (req_valid) begin
                req_err   <= err_now;
                cmd_code  <= err_now ? 4'h0 : p_cmd;
                adr_code  <= err_now ? 4'h0 : p_adr;
                dac       <= !err_now && p_dac;
                cfg_type  <= !err_now && p_cfg && c_type;
                idsel     <= (!err_now && p_cfg) ? c_sel : '0;
                bus_addr  <= err_now ? '0 :
                             p_cfg ? {{PAD_W{1'b0}}, c_reg} : req_addr;
                bus_wdata <= req_wdata;
            end
        end
    end

    // R3
    property mwi_gate_p;
        @(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 3'd1 && (!mwi_en || cls == '0 || req_words <= cls))
        |=> (cmd_code == 4'h7);
    endproperty
    mwi_gate_chk: assert property (mwi_gate_p);

    // R4
    property low_addr_p;
        @(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind <= 3'd1 && req_addr[ADDR_W-1:32] == '0)
        |=> (!dac && adr_code == cmd_code);
    endproperty
    low_addr_chk: assert property (low_addr_p);

    // R6
    property sel_onehot_p;
        @(posedge clk) disable iff (!rst_n)
        out_valid |-> $onehot0(idsel) && (!cfg_type || idsel == '0);
    endproperty
    sel_onehot_chk: assert property (sel_onehot_p);

    // R7
    property no_host_p;
        @(posedge clk) disable iff (!rst_n)
        (req_valid && (req_kind == 3'd2 || req_kind == 3'd3) && !host_mode)
        |=> (out_valid && req_err);
    endproperty
    no_host_chk: assert property (no_host_p);
endmodule

// File: tb/sim_pci_cmd_select.sv
`timescale 1ns/1ps
module sim_pci_cmd_select;
    typedef struct packed {
        logic        err;
        logic [3:0]  cmd;
        logic [3:0]  ac;
        logic        dac;
        logic        ct;
        logic [20:0] sel;
        logic [39:0] addr;
        logic [31:0] wd;
    } exp_t;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0; logic [2:0] req_kind = 0; logic [39:0] req_addr = 0;
    logic [7:0] req_words = 0; logic [31:0] req_wdata = 0;
    logic mwi_en = 0; logic [7:0] cls = 0; logic berr_on_rd = 1; logic host_mode = 1;
    logic cfg_we = 0; logic [31:0] cfg_wdata = 0;
    logic rsp_valid = 0, rsp_abort = 0; logic [31:0] rsp_data = 0;
    logic out_valid, req_err, dac, cfg_type, rd_valid, rd_berr;
    logic [3:0] cmd_code, adr_code; logic [20:0] idsel;
    logic [39:0] bus_addr; logic [31:0] bus_wdata, rd_data;

    int total = 0, bad = 0;
    exp_t cq[$]; string ctag[$];
    logic [32:0] rq[$]; string rtag[$];
    logic [31:0] cfg_shadow = 0;

    always #5 clk = ~clk;

    pci_cmd_select u0 (.*);

    task automatic chk(input bit ok, input string tag, input string act, input string exp);
        total++;
        if (!ok) begin bad++; $display("FAIL %s actual=%s expected=%s", tag, act, exp); end
    endtask

    // Driver: compute expected result from the requirements and push it.
    task automatic send(input logic [2:0] k, input logic [39:0] a, input logic [7:0] w,
                        input logic m, input logic [7:0] c, input logic [31:0] d, input string tag);
        exp_t e; logic [4:0] dv;
        e = '0; e.wd = d;
        case (k)
            3'd0, 3'd1: begin
                e.cmd = (k == 3'd0) ? 4'h6 : ((m && c != 0 && w > c) ? 4'hF : 4'h7);
                e.dac = (a > 40'h00_FFFF_FFFF);
                e.ac = e.dac ? 4'hD : e.cmd; e.addr = a;
            end
            3'd2, 3'd3: begin
                if (!host_mode || cfg_shadow[1]) e.err = 1;
                else begin
                    e.cmd = (k == 3'd2) ? 4'hA : 4'hB; e.ac = e.cmd;
                    e.addr = {8'h0, cfg_shadow};
                    e.ct = cfg_shadow[0];
                    dv = cfg_shadow[15:11];
                    if (!e.ct && dv < 21) e.sel[dv] = 1'b1;
                end
            end
            3'd4: begin e.cmd = 4'h0; e.ac = 4'h0; e.addr = a; end
            3'd5: begin e.cmd = 4'h1; e.ac = 4'h1; e.addr = a; end
            default: e.err = 1;
        endcase
        if (e.err) begin e.cmd = 0; e.ac = 0; e.dac = 0; e.ct = 0; e.sel = 0; e.addr = 0; end
        @(negedge clk);
        req_valid = 1; req_kind = k; req_addr = a; req_words = w;
        mwi_en = m; cls = c; req_wdata = d;
        cq.push_back(e); ctag.push_back(tag);
        @(negedge clk); req_valid = 0;
    endtask

    task automatic set_cfg(input logic [31:0] v);
        @(negedge clk); cfg_we = 1; cfg_wdata = v;
        @(negedge clk); cfg_we = 0; cfg_shadow = v;
    endtask

    task automatic resp(input logic ab, input logic be, input logic [31:0] d, input string tag);
        @(negedge clk);
        rsp_valid = 1; rsp_abort = ab; berr_on_rd = be; rsp_data = d;
        if (!ab) rq.push_back({1'b0, d});
        else if (be) rq.push_back({1'b1, 32'h0});
        else rq.push_back({1'b0, 32'hFFFF_FFFF});
        rtag.push_back(tag);
        @(negedge clk); rsp_valid = 0;
    endtask

    // Monitor: pop and compare whenever the design produces a result.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            exp_t g; exp_t e; string t;
            g = {req_err, cmd_code, adr_code, dac, cfg_type, idsel, bus_addr, bus_wdata};
            if (cq.size() == 0) chk(0, "R2 unexpected out_valid", $sformatf("%h", g), "none");
            else begin
                e = cq.pop_front(); t = ctag.pop_front();
                if (e.err) chk(req_err == 1'b1, t, $sformatf("err=%b", req_err), "err=1");
                else chk(g == e, t, $sformatf("%h", g), $sformatf("%h", e));
            end
        end
        if (rst_n && rd_valid) begin
            logic [32:0] r; string t;
            if (rq.size() == 0) chk(0, "R9 unexpected rd_valid", "1", "0");
            else begin
                r = rq.pop_front(); t = rtag.pop_front();
                chk({rd_berr, rd_data} == r, t, $sformatf("%h", {rd_berr, rd_data}), $sformatf("%h", r));
            end
        end
    end

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(out_valid == 0 && req_err == 0, "R1 out after reset", $sformatf("%b%b", out_valid, req_err), "00");
        chk(rd_valid == 0 && rd_berr == 0, "R1 rd after reset", $sformatf("%b%b", rd_valid, rd_berr), "00");
        @(negedge clk); rst_n = 1;

        send(3'd0, 40'h00_1234_5678, 0, 0, 0, 0, "R2 mem read");
        send(3'd0, 40'h00_FFFF_FFFF, 0, 0, 0, 0, "R4 dac edge low");
        send(3'd0, 40'h01_0000_0000, 0, 0, 0, 0, "R4 dac edge high");
        send(3'd1, 40'h00_0000_1000, 8'd9, 1, 8'd8, 32'hA5, "R3 mwi all met");
        send(3'd1, 40'h00_0000_1000, 8'd8, 1, 8'd8, 32'hA6, "R3 words equal cls");
        send(3'd1, 40'h00_0000_1000, 8'd9, 1, 8'd0, 32'hA7, "R3 cls zero");
        send(3'd1, 40'h00_0000_1000, 8'd9, 0, 8'd8, 32'hA8, "R3 enable off");
        send(3'd1, 40'hF0_0000_0040, 8'd20, 1, 8'd4, 32'hA9, "R4 R3 high mwi");
        set_cfg(32'h0000_1A04 | (32'd3 << 11));
        send(3'd2, 0, 0, 0, 0, 0, "R5 R6 cfg read type0 dev3");
        send(3'd3, 0, 0, 0, 0, 32'h55, "R5 cfg write type0");
        set_cfg((32'd25 << 11) | 32'h100);
        send(3'd2, 0, 0, 0, 0, 0, "R6 dev beyond selects");
        set_cfg(32'h00AB_CD01);
        send(3'd2, 0, 0, 0, 0, 0, "R6 type1");
        set_cfg(32'h00AB_CD02);
        send(3'd3, 0, 0, 0, 0, 0, "R6 bad type code");
        set_cfg(32'h0000_2000);
        host_mode = 0;
        send(3'd2, 0, 0, 0, 0, 0, "R7 non-host cfg");
        host_mode = 1;
        send(3'd4, 40'h0, 0, 0, 0, 0, "R2 iack command");
        send(3'd5, 40'h0, 0, 0, 0, 32'hDEAD_BEEF, "R8 special cycle data");
        send(3'd7, 40'h0, 0, 0, 0, 0, "R2 bad kind");
        resp(0, 1, 32'h0000_0042, "R9 iack data");
        resp(1, 1, 32'h1234_5678, "R10 abort with berr");
        resp(1, 0, 32'h1234_5678, "R11 abort all ones");
        resp(0, 0, 32'hCAFE_0001, "R9 plain read");
        repeat (4) @(negedge clk);
        chk(cq.size() == 0 && rq.size() == 0, "R2 all results seen",
            $sformatf("%0d/%0d", cq.size(), rq.size()), "0/0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule